// File: doc/BRIEF.md
# Tester Drive Waveform Formatter

This block shapes the drive waveform of a single tester pin, one tester cycle (a slice) at a time. A free-running slice counter counts clock ticks from 0 to `period_i - 1`. Tick 0 is the slice start (t0). Two programmable tick offsets, `t1_i` and `t2_i`, mark the leading and trailing edges inside the slice. One data bit is loaded per slice over a valid/ready handshake. The pin level for every tick follows from that bit, the bit of the previous slice and a 3-bit shape code.

The handshake is offered only in the t0 tick. If no bit is presented there, the previous bit is reused for the whole slice and an underrun flag stays raised until the next t0. The pin is registered, so the level for the tick with counter value c appears on `pin_o` one clock later. Timing inputs and the shape code are meant to be held stable while a slice is in progress.

Top module: `drv_wave_fmt`

## Requirements
- R1: While reset is asserted, `pin_o` and `underrun_o` are 0. In the first cycle after release, `data_ready_o` is 1, because the block starts at t0 of slice 0.
- R2: `data_ready_o` is 1 exactly in the ticks where the counter is 0. The counter runs 0 .. `period_i`-1 and wraps, so ready recurs every `period_i` cycles (`period_i` >= 2).
- R3: The bit offered with `data_valid_i` at t0 becomes the slice bit. With no valid at t0, the previous slice bit is repeated and `underrun_o` is 1 for that slice. `underrun_o` is 0 for a slice whose bit was accepted, and it changes only after a t0 tick.
- R4: Code 0 (non-return): from t1 the pin carries the slice bit. Before t1 it keeps the previous slice bit.
- R5: Code 1 (return-high) and code 2 (return-low): from t1 to t2 the pin carries the slice bit. From t2 to the end of the slice it is 1 (code 1) or 0 (code 2). Before t1 it keeps its level.
- R6: Code 3 (pulse-high): the pin is 1 from t1 to t2 when the slice bit is 1, and 0 otherwise. Code 4 (pulse-low) is the exact complement.
- R7: Code 5 (pulse-high skew): a slice bit of 1 drives the pin to 1 from t1 of that slice up to t2 of the next slice, and the pin is 0 elsewhere. Code 6 is the complement. For these codes t1 >= t2 is allowed.
- R8: Code 7 (surround by complement): the pin carries the slice bit from t1 to t2 and its complement for the rest of the slice.
- R9: Every window is half-open (counter >= t1 and counter < t2). The level for counter value c is seen on `pin_o` one clock later. A setting of period 20, t1 15, t2 18 is supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | tick clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| period_i | input | CNT_W | slice length in ticks |
| t1_i | input | CNT_W | leading-edge offset from t0 |
| t2_i | input | CNT_W | trailing-edge offset from t0 |
| fmt_i | input | 3 | shape code |
| data_valid_i | input | 1 | slice bit offered |
| data_i | input | 1 | slice bit |
| data_ready_o | output | 1 | t0 tick, bit accepted when valid |
| pin_o | output | 1 | shaped pin level |
| underrun_o | output | 1 | current slice reused the previous bit |

## Verification
The slice-boundary fetch and the pin shaping fall in the same t0 tick. In that tick the incoming bit (or the repeated bit on underrun) must already steer the pin, while the previous-slice bit must still be the one that was just completed. The bench provokes this with skew shapes whose trailing edge lands in the next slice, with t1 = 0-like windows near t0, and with deliberate gaps in the handshake. A reference model stepping tick by tick judges every cycle for pin level, ready and underrun.

// File: rtl/drv_wave_pkg.sv
package drv_wave_pkg;
  typedef enum logic [2:0] {
    FMT_NR  = 3'd0,
    FMT_RH  = 3'd1,
    FMT_RL  = 3'd2,
    FMT_PH  = 3'd3,
    FMT_PL  = 3'd4,
    FMT_PHS = 3'd5,
    FMT_PLS = 3'd6,
    FMT_SBC = 3'd7
  } fmt_e;
endpackage

// File: rtl/slice_timer.sv
module slice_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] t1_i,
  input  logic [CNT_W-1:0] t2_i,
  output logic             at_t0_o,
  output logic             past_t1_o,
  output logic             before_t2_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_tick;

  assign last_tick = period_i - ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (cnt_q >= last_tick) cnt_q <= '0;
    else                        cnt_q <= cnt_q + ONE;
  end

  assign at_t0_o     = (cnt_q == '0);
  assign past_t1_o   = (cnt_q >= t1_i);
  assign before_t2_o = (cnt_q < t2_i);
endmodule

// File: rtl/slice_data.sv
module slice_data (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic at_t0_i,
  input  logic valid_i,
  input  logic data_i,
  output logic cur_o,
  output logic prev_o,
  output logic underrun_o
);
  logic last_q, prev_q, und_q;

  // at t0 the new slice is already live; the finished slice is last_q
  assign cur_o  = at_t0_i ? (valid_i ? data_i : last_q) : last_q;
  assign prev_o = at_t0_i ? last_q : prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
      prev_q <= 1'b0;
      und_q  <= 1'b0;
    end else if (at_t0_i) begin
      prev_q <= last_q;
      last_q <= cur_o;
      und_q  <= !valid_i;
    end
  end

  assign underrun_o = und_q;
endmodule

// File: rtl/wave_shaper.sv
module wave_shaper
  import drv_wave_pkg::*;
(
  input  logic [2:0] fmt_i,
  input  logic       cur_i,
  input  logic       prev_i,
  input  logic       past_t1_i,
  input  logic       before_t2_i,
  input  logic       pin_q_i,
  output logic       pin_d_o
);
  logic win, skew_act;

  assign win      = past_t1_i && before_t2_i;
  assign skew_act = (past_t1_i && cur_i) || (before_t2_i && prev_i);

  always_comb begin
    unique case (fmt_e'(fmt_i))
      FMT_NR:  pin_d_o = past_t1_i ? cur_i : prev_i;
      FMT_RH:  pin_d_o = (past_t1_i && !before_t2_i) ? 1'b1 : (win ? cur_i : pin_q_i);
      FMT_RL:  pin_d_o = (past_t1_i && !before_t2_i) ? 1'b0 : (win ? cur_i : pin_q_i);
      FMT_PH:  pin_d_o = win && cur_i;
      FMT_PL:  pin_d_o = !(win && cur_i);
      FMT_PHS: pin_d_o = skew_act;
      FMT_PLS: pin_d_o = !skew_act;
      FMT_SBC: pin_d_o = win ? cur_i : !cur_i;
      default: pin_d_o = pin_q_i;
    endcase
  end
endmodule

// File: rtl/drv_wave_fmt.sv
module drv_wave_fmt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] t1_i,
  input  logic [CNT_W-1:0] t2_i,
  input  logic [2:0]       fmt_i,
  input  logic             data_valid_i,
  input  logic             data_i,
  output logic             data_ready_o,
  output logic             pin_o,
  output logic             underrun_o
);
  logic at_t0, past_t1, before_t2;
  logic cur_bit, prev_bit, pin_d, pin_q;

  slice_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .period_i    (period_i),
    .t1_i        (t1_i),
    .t2_i        (t2_i),
    .at_t0_o     (at_t0),
    .past_t1_o   (past_t1),
    .before_t2_o (before_t2)
  );

  slice_data u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .at_t0_i    (at_t0),
    .valid_i    (data_valid_i),
    .data_i     (data_i),
    .cur_o      (cur_bit),
    .prev_o     (prev_bit),
    .underrun_o (underrun_o)
  );

  wave_shaper u_shape (
    .fmt_i       (fmt_i),
    .cur_i       (cur_bit),
    .prev_i      (prev_bit),
    .past_t1_i   (past_t1),
    .before_t2_i (before_t2),
    .pin_q_i     (pin_q),
    .pin_d_o     (pin_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_d;
  end

  assign pin_o        = pin_q;
  assign data_ready_o = at_t0;
endmodule

// File: rtl/drv_wave_fmt_chk.sv
module drv_wave_fmt_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] period_i,
  input logic [2:0]       fmt_i,
  input logic             data_valid_i,
  input logic             data_ready_o,
  input logic             underrun_o,
  input logic             pin_o,
  input logic             past_t1_i,
  input logic             before_t2_i,
  input logic             cur_i
);
  AST_T0_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_ready_o && period_i > CNT_W'(1)) |=> !data_ready_o);  // R2
  AST_UNDERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_ready_o && !data_valid_i) |=> underrun_o);  // R3
  AST_UNDERRUN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_ready_o && data_valid_i) |=> !underrun_o);  // R3
  AST_UNDERRUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_ready_o |=> $stable(underrun_o));  // R3
  AST_RH_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == 3'd1 && past_t1_i && !before_t2_i) |=> pin_o);  // R5
  AST_PULSE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == 3'd3 && !past_t1_i) |=> !pin_o);  // R6
  AST_SBC_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == 3'd7 && past_t1_i && before_t2_i) |=> (pin_o == $past(cur_i)));  // R8
endmodule

bind drv_wave_fmt drv_wave_fmt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .period_i     (period_i),
  .fmt_i        (fmt_i),
  .data_valid_i (data_valid_i),
  .data_ready_o (data_ready_o),
  .underrun_o   (underrun_o),
  .pin_o        (pin_o),
  .past_t1_i    (past_t1),
  .before_t2_i  (before_t2),
  .cur_i        (cur_bit)
);

// File: tb/drv_wave_fmt_bench.sv
module drv_wave_fmt_bench;
  localparam int CNT_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CNT_W-1:0] period_i = 8'd20;
  logic [CNT_W-1:0] t1_i = 8'd15;
  logic [CNT_W-1:0] t2_i = 8'd18;
  logic [2:0]       fmt_i = 3'd0;
  logic             data_valid_i = 1'b0;
  logic             data_i = 1'b0;
  logic             data_ready_o, pin_o, underrun_o;

  int checks = 0;
  int errors = 0;

  int   m_cnt = 0;
  logic m_last = 1'b0, m_prev = 1'b0, m_pin = 1'b0, m_und = 1'b0;

  always #10 clk_i = ~clk_i;

  drv_wave_fmt #(.CNT_W(CNT_W)) u_drv_wave_fmt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .period_i     (period_i),
    .t1_i         (t1_i),
    .t2_i         (t2_i),
    .fmt_i        (fmt_i),
    .data_valid_i (data_valid_i),
    .data_i       (data_i),
    .data_ready_o (data_ready_o),
    .pin_o        (pin_o),
    .underrun_o   (underrun_o)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at t=%0t: actual %b expected %b", tag, what, $time, act, exp);
    end
  endtask

  // one tick of the reference model, then compare at the following negedge
  task automatic step(input logic v, input logic d, input string tag);
    logic at, cur, prv, ge, lt, win, act, pn;
    data_valid_i = v;
    data_i       = d;
    at  = (m_cnt == 0);
    cur = at ? (v ? d : m_last) : m_last;
    prv = at ? m_last : m_prev;
    ge  = (m_cnt >= int'(t1_i));
    lt  = (m_cnt < int'(t2_i));
    win = ge && lt;
    act = (ge && cur) || (lt && prv);
    case (fmt_i)
      3'd0: pn = ge ? cur : prv;
      3'd1: pn = (ge && !lt) ? 1'b1 : (win ? cur : m_pin);
      3'd2: pn = (ge && !lt) ? 1'b0 : (win ? cur : m_pin);
      3'd3: pn = win && cur;
      3'd4: pn = !(win && cur);
      3'd5: pn = act;
      3'd6: pn = !act;
      default: pn = win ? cur : !cur;
    endcase
    if (at) begin
      m_prev = m_last;
      m_last = cur;
      m_und  = !v;
    end
    m_pin = pn;
    m_cnt = (m_cnt >= int'(period_i) - 1) ? 0 : m_cnt + 1;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(tag, "pin_o", pin_o, m_pin);
    chk("R3", "underrun_o", underrun_o, m_und);
    chk("R2", "data_ready_o", data_ready_o, logic'(m_cnt == 0));
  endtask

  task automatic run_shape(input logic [2:0] f, input int per, input int a, input int b,
                           input logic [7:0] bits, input logic [7:0] gaps, input int nsl,
                           input string tag);
    int idx;
    fmt_i    = f;
    period_i = CNT_W'(per);
    t1_i     = CNT_W'(a);
    t2_i     = CNT_W'(b);
    idx      = -1;
    for (int c = 0; c < nsl * per; c++) begin
      if (m_cnt == 0) idx++;
      if (m_cnt == 0 && !gaps[idx]) step(1'b1, bits[idx], tag);
      else                          step(1'b0, 1'b0, tag);
    end
  endtask

  task automatic test_reset();
    chk("R1", "pin_o in reset", pin_o, 1'b0);
    chk("R1", "underrun_o in reset", underrun_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1", "data_ready_o after release", data_ready_o, 1'b1);
  endtask

  task automatic test_non_return();
    run_shape(3'd0, 20, 15, 18, 8'b0000_1101, 8'h00, 4, "R4 R9");
  endtask

  task automatic test_return();
    run_shape(3'd1, 12, 4, 9, 8'b0000_1010, 8'h00, 4, "R5");
    run_shape(3'd2, 12, 4, 9, 8'b0000_0101, 8'h00, 4, "R5");
  endtask

  task automatic test_pulse();
    run_shape(3'd3, 10, 2, 7, 8'b0000_1011, 8'h00, 4, "R6");
    run_shape(3'd4, 10, 3, 6, 8'b0000_0110, 8'h00, 4, "R6");
  endtask

  task automatic test_skew();
    run_shape(3'd5, 10, 6, 3, 8'b0001_1011, 8'h00, 5, "R7");
    run_shape(3'd6, 10, 2, 5, 8'b0000_1101, 8'h00, 4, "R7");
  endtask

  task automatic test_complement();
    run_shape(3'd7, 9, 1, 6, 8'b0000_1001, 8'h00, 4, "R8");
    run_shape(3'd7, 9, 0, 9, 8'b0000_0110, 8'h00, 4, "R8 R9");
  endtask

  task automatic test_underrun();
    run_shape(3'd0, 8, 3, 5, 8'b0000_0001, 8'b0000_1010, 4, "R3");
    run_shape(3'd5, 8, 6, 2, 8'b0000_0001, 8'b0000_0110, 4, "R3 R7");
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #35;
    test_reset();
    test_non_return();
    test_return();
    test_pulse();
    test_skew();
    test_complement();
    test_underrun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule